// File: doc/BRIEF.md
# Prescaled Match/Capture Timer

This block is a word-addressed timer peripheral built around a counter of up to 32 bits. A programmable prescaler divides the system clock before it reaches the counter. The counter can also ignore the clock and step on edges of one of the external capture inputs. Four compare channels watch the counter. Each channel can independently flag an interrupt, restart the counter from zero, or freeze both counters. Each channel also has an external output that it can clear, set or invert when it fires.

Two capture channels take a snapshot of the counter when a chosen edge arrives on their input. They can also raise an interrupt. Pending interrupts collect in one write-one-to-clear register, and a single interrupt line goes high while any of them is pending. Software configures everything through a flat register file with single-cycle writes and combinational reads. The counters, compare values and snapshots can all be read back at any time.

A compare channel "fires" in the cycle where the counter equals its compare value and is about to advance. Its action therefore applies as the counter leaves that value. With restart enabled, the counter runs through 0..M and the period is (M+1)·(P+1) clocks.

Top module: `pmc_timer`

## Requirements
- R1: After reset every register reads zero, `irq` and `match_out` are low, and every unmapped word offset between 0x00 and 0x7C reads zero.
- R2: In clock mode with run set, the prescale counter (0x10) counts 0..P, where P is the prescale value at 0x0C. The main counter (0x08) advances once per P+1 clocks, so K clocks after starting from zero it reads K/(P+1) and the prescale counter reads K mod (P+1).
- R3: Control register 0x04: bit 0 is run and bit 1 is hold. While hold is 1, both counters are forced to zero. While run is 0, both counters keep their value.
- R4: When bit 3n+1 of the match control word (0x14) is set, a firing of channel n sends the main counter to zero instead of incrementing it. The counter then cycles through 0..M, where M is the compare value at 0x18+4n.
- R5: When bit 3n+2 of the match control word is set, a firing of channel n leaves the main counter at M and the prescale counter at 0, and clears the run bit. This rule takes priority over a software write to run in the same cycle.
- R6: A firing of channel n sets flag bit n at 0x00 only when bit 3n of the match control word is set. With that bit clear, the flag stays 0.
- R7: Capture control 0x28 holds three bits per input i: bit 3i captures on rising edges, bit 3i+1 on falling edges, and bit 3i+2 enables the interrupt. On a selected edge, the capture register at 0x2C+4i loads the counter value that is present two clock edges after the first edge that samples the new input level. Flag bit 4+i is set when the interrupt enable is on. An edge type that is not selected leaves the capture register unchanged.
- R8: Writing 1 to a bit of 0x00 clears that flag, but a new event on the same flag in the same cycle keeps it set. `irq` is high exactly while any flag is set.
- R9: Count mode 0x70: bits 1:0 select the count source, where 0 is the prescaled clock, 1 rising edges, 2 falling edges and 3 both edges. Bit 2 selects capture input 0 or 1. In an edge mode, each qualifying edge of the synchronized input advances the counter by exactly one.
- R10: External match word 0x3C: bits 3:0 are the output levels, driven on `match_out` and writable. The 2-bit field at 4+2n sets channel n's action on firing: 0 keep, 1 clear, 2 set, 3 invert.
- R11: Software writes to the main counter, the prescale counter and the compare values read back unchanged while the counter is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register word |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| cap_in | input | N_CAP | Asynchronous capture / count inputs |
| match_out | output | N_MATCH | External match output levels |
| irq | output | 1 | OR of all pending flags |

## Verification
Timing of results after a stimulus:
- A register write takes effect at the clock edge that accepts it, and reads are combinational.
- The counters therefore reflect K further edges after K negative-edge waits. The accepting edge of a write to run also counts, and the bench adds it to its expectation.
- Flags, external outputs and the run bit change at the edge where a channel fires. That edge is the (P+1)-th edge spent on the compare value.
- A capture input change is sampled at the next edge and detected after the second. The snapshot and flag land at the third edge, so the bench waits three edges before reading.

All sampling happens at negative edges, or 1 ns after them, with expectations computed from these counts.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   localparam int unsigned BUS_W = 32;
   localparam int unsigned FLAG_W = 8;
   localparam int unsigned CAP_FLAG_BASE = 4;

   localparam logic [7:0] OFS_FLAGS  = 8'h00;
   localparam logic [7:0] OFS_CTRL   = 8'h04;
   localparam logic [7:0] OFS_COUNT  = 8'h08;
   localparam logic [7:0] OFS_PSVAL  = 8'h0C;
   localparam logic [7:0] OFS_PSCNT  = 8'h10;
   localparam logic [7:0] OFS_MCTL   = 8'h14;
   localparam logic [7:0] OFS_MATCH0 = 8'h18;
   localparam logic [7:0] OFS_CCTL   = 8'h28;
   localparam logic [7:0] OFS_CAPT0  = 8'h2C;
   localparam logic [7:0] OFS_EXTM   = 8'h3C;
   localparam logic [7:0] OFS_MODE   = 8'h70;

   typedef enum logic [1:0] {
      EXT_KEEP = 2'd0,
      EXT_CLR  = 2'd1,
      EXT_SET  = 2'd2,
      EXT_FLIP = 2'd3
   } ext_act_e;

   typedef enum logic [1:0] {
      SRC_CLOCK = 2'd0,
      SRC_RISE  = 2'd1,
      SRC_FALL  = 2'd2,
      SRC_BOTH  = 2'd3
   } cnt_src_e;
endpackage

// File: rtl/pmc_edge_sync.sv
module pmc_edge_sync #(
   parameter int unsigned N_IN   = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_IN-1:0] din,
   output logic [N_IN-1:0] rise,
   output logic [N_IN-1:0] fall
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pmc_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   for (genvar i = 0; i < N_IN; i++) begin : g_ch
      // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
      logic [STAGES:0] pipe;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe <= '0;
         else        pipe <= {pipe[STAGES-1:0], din[i]};
      end

      assign rise[i] =  pipe[STAGES-1] & ~pipe[STAGES];
      assign fall[i] = ~pipe[STAGES-1] &  pipe[STAGES];

      AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
         (rise[i] || fall[i]) |=> !(rise[i] || fall[i])); // R9
   end
endmodule

// File: rtl/pmc_count_core.sv
module pmc_count_core #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             hold,
   input  logic             ext_mode,
   input  logic             ext_tick,
   input  logic [CNT_W-1:0] ps_limit,
   input  logic             wr_cnt,
   input  logic             wr_ps,
   input  logic [CNT_W-1:0] wr_val,
   input  logic             zap,
   input  logic             halt,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] ps,
   output logic             adv
);
   assign adv = run & ~hold & (ext_mode ? ext_tick : (ps == ps_limit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         ps  <= '0;
      end else if (hold) begin
         cnt <= '0;
         ps  <= '0;
      end else begin
         if (wr_cnt)     cnt <= wr_val;
         else if (adv) begin
            if (zap)        cnt <= '0;
            else if (!halt) cnt <= cnt + 1'b1;
         end
         if (wr_ps)          ps <= wr_val;
         else if (!ext_mode) begin
            if (adv)      ps <= '0;
            else if (run) ps <= ps + 1'b1;
         end
      end
   end

   AST_ADVANCE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !wr_cnt && !zap && !halt) |=> cnt == $past(cnt) + 1'b1); // R2
   AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (cnt == '0 && ps == '0)); // R3
   AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !hold && !wr_cnt && !wr_ps) |=> (cnt == $past(cnt) && ps == $past(ps))); // R3
   AST_ZAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && zap && !wr_cnt) |=> cnt == '0); // R4
endmodule

// File: rtl/pmc_match_bank.sv
module pmc_match_bank #(
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned N_MATCH = 4
) (
   input  logic [CNT_W-1:0]              cnt,
   input  logic                          adv,
   input  logic [N_MATCH-1:0][CNT_W-1:0] targets,
   output logic [N_MATCH-1:0]            hit
);
   for (genvar n = 0; n < N_MATCH; n++) begin : g_cmp
      assign hit[n] = adv & (cnt == targets[n]);
   end
endmodule

// File: rtl/pmc_timer.sv
module pmc_timer
   import pmc_pkg::*;
#(
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned N_MATCH     = 4,
   parameter int unsigned N_CAP       = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [7:0]         bus_addr,
   input  logic               bus_wr,
   input  logic [BUS_W-1:0]   bus_wdata,
   output logic [BUS_W-1:0]   bus_rdata,
   input  logic [N_CAP-1:0]   cap_in,
   output logic [N_MATCH-1:0] match_out,
   output logic               irq
);
   localparam int unsigned SEL_W  = (N_CAP > 1) ? $clog2(N_CAP) : 1;
   localparam int unsigned MCTL_W = 3 * N_MATCH;
   localparam int unsigned CCTL_W = 3 * N_CAP;
   localparam int unsigned ACT_W  = 2 * N_MATCH;

   generate
      if (N_MATCH < 1 || N_MATCH > 4) begin : g_bad_match
         $error("pmc_timer: N_MATCH must be 1..4");
      end
      if (N_CAP < 1 || N_CAP > 2) begin : g_bad_cap
         $error("pmc_timer: N_CAP must be 1..2");
      end
      if (CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_width
         $error("pmc_timer: CNT_W must be 2..32");
      end
   endgenerate

   // register state
   logic                          ctrl_run, ctrl_hold;
   logic [CNT_W-1:0]              ps_limit;
   logic [MCTL_W-1:0]             mctl;
   logic [CCTL_W-1:0]             cctl;
   logic [ACT_W-1:0]              ext_act;
   cnt_src_e                      mode_src;
   logic [SEL_W-1:0]              mode_sel;
   logic [FLAG_W-1:0]             flags, flag_set, flag_clr;
   logic [N_MATCH-1:0][CNT_W-1:0] targets;
   logic [N_CAP-1:0][CNT_W-1:0]   capt;
   logic [N_MATCH-1:0]            ext_lvl, hit, mc_irq, mc_zap, mc_halt;
   logic [N_CAP-1:0]              rise, fall, cap_evt;
   logic [CNT_W-1:0]              cnt, ps;
   logic                          adv, zap_evt, halt_evt, ext_tick, sel_rise, sel_fall;

   function automatic logic wr_at(input logic [7:0] ofs);
      return bus_wr && (bus_addr == ofs);
   endfunction

   pmc_edge_sync #(.N_IN(N_CAP), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(cap_in), .rise(rise), .fall(fall));

   assign sel_rise = (int'(mode_sel) < N_CAP) ? rise[mode_sel] : 1'b0;
   assign sel_fall = (int'(mode_sel) < N_CAP) ? fall[mode_sel] : 1'b0;
   always_comb begin
      unique case (mode_src)
         SRC_RISE: ext_tick = sel_rise;
         SRC_FALL: ext_tick = sel_fall;
         SRC_BOTH: ext_tick = sel_rise | sel_fall;
         default:  ext_tick = 1'b0;
      endcase
   end

   pmc_count_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .run(ctrl_run), .hold(ctrl_hold),
      .ext_mode(mode_src != SRC_CLOCK), .ext_tick(ext_tick), .ps_limit(ps_limit),
      .wr_cnt(wr_at(OFS_COUNT)), .wr_ps(wr_at(OFS_PSCNT)), .wr_val(bus_wdata[CNT_W-1:0]),
      .zap(zap_evt), .halt(halt_evt), .cnt(cnt), .ps(ps), .adv(adv));

   pmc_match_bank #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_match (
      .cnt(cnt), .adv(adv), .targets(targets), .hit(hit));

   assign zap_evt  = |(hit & mc_zap);
   assign halt_evt = |(hit & mc_halt);

   // per compare channel: target register, action bits, external output
   for (genvar n = 0; n < N_MATCH; n++) begin : g_ch
      logic [CNT_W-1:0] tgt_q;
      logic             lvl_q;
      ext_act_e         act;

      assign mc_irq[n]  = mctl[3*n];
      assign mc_zap[n]  = mctl[3*n+1];
      assign mc_halt[n] = mctl[3*n+2];
      assign act        = ext_act_e'(ext_act[2*n +: 2]);
      assign targets[n] = tgt_q;
      assign ext_lvl[n] = lvl_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tgt_q <= '0;
            lvl_q <= 1'b0;
         end else begin
            if (wr_at(OFS_MATCH0 + 8'(4 * n))) tgt_q <= bus_wdata[CNT_W-1:0];
            if (hit[n]) begin
               unique case (act)
                  EXT_CLR:  lvl_q <= 1'b0;
                  EXT_SET:  lvl_q <= 1'b1;
                  EXT_FLIP: lvl_q <= ~lvl_q;
                  default:  lvl_q <= lvl_q;
               endcase
            end else if (wr_at(OFS_EXTM)) begin
               lvl_q <= bus_wdata[n];
            end
         end
      end

      AST_EXT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
         (hit[n] && act == EXT_FLIP) |=> lvl_q != $past(lvl_q)); // R10
   end

   // per capture channel: edge qualification and snapshot
   for (genvar i = 0; i < N_CAP; i++) begin : g_cap
      logic [CNT_W-1:0] snap_q;
      assign cap_evt[i] = (rise[i] & cctl[3*i]) | (fall[i] & cctl[3*i+1]);
      assign capt[i]    = snap_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          snap_q <= '0;
         else if (cap_evt[i]) snap_q <= cnt;
      end

      AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
         cap_evt[i] |=> snap_q == $past(cnt)); // R7
   end

   always_comb begin
      flag_set = '0;
      for (int n = 0; n < N_MATCH; n++) flag_set[n] = hit[n] & mc_irq[n];
      for (int i = 0; i < N_CAP; i++)
         flag_set[CAP_FLAG_BASE + i] = cap_evt[i] & cctl[3*i+2];
   end
   assign flag_clr = wr_at(OFS_FLAGS) ? bus_wdata[FLAG_W-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags     <= '0;
         ctrl_run  <= 1'b0;
         ctrl_hold <= 1'b0;
         ps_limit  <= '0;
         mctl      <= '0;
         cctl      <= '0;
         ext_act   <= '0;
         mode_src  <= SRC_CLOCK;
         mode_sel  <= '0;
      end else begin
         flags <= (flags & ~flag_clr) | flag_set;
         if (wr_at(OFS_CTRL)) begin
            ctrl_run  <= bus_wdata[0];
            ctrl_hold <= bus_wdata[1];
         end
         if (halt_evt) ctrl_run <= 1'b0;
         if (wr_at(OFS_PSVAL)) ps_limit <= bus_wdata[CNT_W-1:0];
         if (wr_at(OFS_MCTL))  mctl     <= bus_wdata[MCTL_W-1:0];
         if (wr_at(OFS_CCTL))  cctl     <= bus_wdata[CCTL_W-1:0];
         if (wr_at(OFS_EXTM))  ext_act  <= bus_wdata[4 +: ACT_W];
         if (wr_at(OFS_MODE)) begin
            mode_src <= cnt_src_e'(bus_wdata[1:0]);
            mode_sel <= bus_wdata[2 +: SEL_W];
         end
      end
   end

   assign irq       = |flags;
   assign match_out = ext_lvl;

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         OFS_FLAGS: bus_rdata[FLAG_W-1:0] = flags;
         OFS_CTRL:  bus_rdata[1:0]        = {ctrl_hold, ctrl_run};
         OFS_COUNT: bus_rdata[CNT_W-1:0]  = cnt;
         OFS_PSVAL: bus_rdata[CNT_W-1:0]  = ps_limit;
         OFS_PSCNT: bus_rdata[CNT_W-1:0]  = ps;
         OFS_MCTL:  bus_rdata[MCTL_W-1:0] = mctl;
         OFS_CCTL:  bus_rdata[CCTL_W-1:0] = cctl;
         OFS_EXTM: begin
            bus_rdata[N_MATCH-1:0] = ext_lvl;
            bus_rdata[4 +: ACT_W]  = ext_act;
         end
         OFS_MODE: begin
            bus_rdata[1:0]         = mode_src;
            bus_rdata[2 +: SEL_W]  = mode_sel;
         end
         default: ;
      endcase
      for (int n = 0; n < N_MATCH; n++)
         if (bus_addr == OFS_MATCH0 + 8'(4 * n)) bus_rdata[CNT_W-1:0] = targets[n];
      for (int i = 0; i < N_CAP; i++)
         if (bus_addr == OFS_CAPT0 + 8'(4 * i)) bus_rdata[CNT_W-1:0] = capt[i];
   end

   AST_STOP_DROPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      halt_evt |=> !ctrl_run); // R5
   AST_STOP_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_evt && !zap_evt && !wr_at(OFS_COUNT) && !ctrl_hold) |=> cnt == $past(cnt)); // R5
   AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|flag_set) |=> ((flags & $past(flag_set)) == $past(flag_set))); // R8
   AST_IRQ_LOW_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (flags == '0 && flag_set == '0) |=> !irq); // R8
endmodule

// File: tb/pmc_timer_test.sv
`timescale 1ns/1ps
module pmc_timer_test;
   import pmc_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  cap_in = '0;
   logic [3:0]  match_out;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pmc_timer uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
      .match_out(match_out), .irq(irq));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic halt_all();
      wr(OFS_CTRL, 32'd2);
      wr(OFS_FLAGS, 32'hFF);
   endtask

   function automatic int exp_ticks(input int k, input int p);
      return k / (p + 1);
   endfunction

   function automatic int exp_wrap(input int ticks, input int m);
      return ticks % (m + 1);
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int p, m, k, t, n;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state of every word and the outputs
      for (int a = 0; a < 32; a++) begin
         rd(8'(a * 4), v);
         check($sformatf("R1 reset word %0h", a * 4), v, 32'd0);
      end
      check("R1 irq low", {31'd0, irq}, 32'd0);
      check("R1 match_out low", {28'd0, match_out}, 32'd0);

      // R2 prescaled counting, random prescale values
      for (int it = 0; it < 4; it++) begin
         p = $urandom_range(0, 5);
         halt_all();
         wr(OFS_PSVAL, p);
         wr(OFS_CTRL, 32'd1);
         k = $urandom_range(1, 40);
         idle(k);
         rd(OFS_COUNT, v); check("R2 count", v, exp_ticks(k, p));
         rd(OFS_PSCNT, v); check("R2 prescale count", v, k % (p + 1));
      end

      // R3 run cleared freezes, hold forces zero
      wr(OFS_CTRL, 32'd0);
      k = k + 1;
      idle(7);
      rd(OFS_COUNT, v); check("R3 frozen count", v, exp_ticks(k, p));
      rd(OFS_PSCNT, v); check("R3 frozen prescale", v, k % (p + 1));
      wr(OFS_CTRL, 32'd3);
      idle(5);
      rd(OFS_COUNT, v); check("R3 hold count", v, 32'd0);
      rd(OFS_PSCNT, v); check("R3 hold prescale", v, 32'd0);

      // R4 restart on match with interrupt, R8 flag
      for (int it = 0; it < 3; it++) begin
         p = $urandom_range(0, 3);
         m = $urandom_range(1, 5);
         halt_all();
         wr(OFS_PSVAL, p);
         wr(OFS_MATCH0, m);
         wr(OFS_MCTL, 32'h3);
         wr(OFS_FLAGS, 32'hFF);
         wr(OFS_CTRL, 32'd1);
         k = $urandom_range(1, 60);
         idle(k);
         t = exp_ticks(k, p);
         rd(OFS_COUNT, v); check("R4 wrapped count", v, exp_wrap(t, m));
         rd(OFS_FLAGS, v); check("R6 match flag", v, (t >= m + 1) ? 32'd1 : 32'd0);
         check("R8 irq follows flags", {31'd0, irq}, (t >= m + 1) ? 32'd1 : 32'd0);
      end

      // R8 clear collides with a new event: flag stays
      halt_all();
      wr(OFS_PSVAL, 32'd0);
      wr(OFS_MATCH0, 32'd0);
      wr(OFS_MCTL, 32'h3);
      wr(OFS_CTRL, 32'd1);
      idle(3);
      wr(OFS_FLAGS, 32'h1);
      rd(OFS_FLAGS, v); check("R8 set wins over clear", v, 32'd1);
      halt_all();
      rd(OFS_FLAGS, v); check("R8 cleared", v, 32'd0);
      check("R8 irq low after clear", {31'd0, irq}, 32'd0);

      // R5 stop on match of channel 1, R6 channel 0 without interrupt enable
      halt_all();
      p = $urandom_range(0, 2);
      m = $urandom_range(3, 6);
      wr(OFS_PSVAL, p);
      wr(OFS_MATCH0, 32'd1);
      wr(OFS_MATCH0 + 8'd4, m);
      wr(OFS_MCTL, 32'h28);
      wr(OFS_CTRL, 32'd1);
      idle((m + 1) * (p + 1) + 6);
      rd(OFS_COUNT, v); check("R5 stopped count", v, m);
      rd(OFS_PSCNT, v); check("R5 stopped prescale", v, 32'd0);
      rd(OFS_CTRL, v);  check("R5 run cleared", v, 32'd0);
      rd(OFS_FLAGS, v); check("R6 only enabled flag set", v, 32'd2);

      // R10 external match actions
      halt_all();
      wr(OFS_PSVAL, 32'd0);
      m = $urandom_range(2, 6);
      wr(OFS_MATCH0, m);
      wr(OFS_MATCH0 + 8'd4, 32'd2);
      wr(OFS_MATCH0 + 8'd8, 32'd1);
      wr(OFS_MCTL, 32'h2);
      wr(OFS_EXTM, 32'h1B4);
      check("R10 written level", {28'd0, match_out}, 32'h4);
      wr(OFS_CTRL, 32'd1);
      k = $urandom_range(3, 30);
      idle(k);
      check("R10 outputs after firing", {28'd0, match_out},
            32'((exp_ticks(k, m) & 1) | 2));
      rd(OFS_EXTM, v); check("R10 readback", v, 32'h1B0 | 32'((exp_ticks(k, m) & 1) | 2));

      // R7 capture rising on input 0 with interrupt, falling on input 1 without
      halt_all();
      wr(OFS_MCTL, 32'd0);
      wr(OFS_PSVAL, 32'd0);
      wr(OFS_CCTL, 32'h15);
      wr(OFS_CTRL, 32'd1);
      k = $urandom_range(2, 20);
      idle(k);
      cap_in[0] = 1'b1;
      idle(3);
      rd(OFS_CAPT0, v); check("R7 rising snapshot", v, k + 2);
      rd(OFS_FLAGS, v); check("R7 capture flag", v, 32'h10);
      cap_in[1] = 1'b1;
      idle(4);
      rd(OFS_CAPT0 + 8'd4, v); check("R7 unselected edge ignored", v, 32'd0);
      cap_in[1] = 1'b0;
      idle(4);
      rd(OFS_CAPT0 + 8'd4, v); check("R7 falling snapshot", v, k + 9);
      rd(OFS_FLAGS, v); check("R7 no flag without enable", v, 32'h10);

      // R9 counting both edges of input 1
      halt_all();
      wr(OFS_CCTL, 32'd0);
      wr(OFS_MODE, 32'h7);
      wr(OFS_CTRL, 32'd1);
      n = $urandom_range(3, 8);
      for (int e = 0; e < n; e++) begin
         cap_in[1] = ~cap_in[1];
         idle(4);
      end
      idle(4);
      rd(OFS_COUNT, v); check("R9 both-edge count", v, n);

      // R9 counting rising edges of input 0
      halt_all();
      wr(OFS_MODE, 32'h1);
      wr(OFS_CTRL, 32'd1);
      n = $urandom_range(2, 6);
      for (int e = 0; e < n; e++) begin
         cap_in[0] = 1'b0;
         idle(4);
         cap_in[0] = 1'b1;
         idle(4);
      end
      idle(3);
      rd(OFS_COUNT, v); check("R9 rising-edge count", v, n);
      wr(OFS_MODE, 32'd0);

      // R11 software writes read back while stopped
      halt_all();
      wr(OFS_CTRL, 32'd0);
      for (int it = 0; it < 3; it++) begin
         logic [31:0] d;
         d = $urandom;
         wr(OFS_COUNT, d);  rd(OFS_COUNT, v);  check("R11 count write", v, d);
         d = $urandom;
         wr(OFS_PSCNT, d);  rd(OFS_PSCNT, v);  check("R11 prescale write", v, d);
         d = $urandom;
         wr(OFS_MATCH0 + 8'd12, d); rd(OFS_MATCH0 + 8'd12, v); check("R11 match write", v, d);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule